// File: doc/BRIEF.md
# Hub Burst Transfer Engine

This block sits on one requester port of a rotating, interleaved long-wide memory. The memory is built from `NSLICE` slices. Each long address lives in the slice named by its low address bits. On every clock the requester port is handed the next slice in ascending order. The engine takes a command made of a byte start address in the hub, a start index in a local 32-bit register file, a direction and a length given as count minus one. It then moves that run of consecutive longs between the hub and the register file.

After a command is accepted, the engine first waits until the slice offered to its port matches the slice holding the start address. It then issues one request on every clock. Because the rotation and the address both advance by one each cycle, every following request lands on the slice offered in that cycle. Hub reads come back one cycle after the request and are written into the register file. Hub writes take their data from a combinational read of the register file in the same cycle. The hub address and the local index both wrap at their natural sizes. A one-cycle done pulse marks the end of the burst.

Top module: `hub_burst_engine`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `busy`, `done`, `hub_req`, `hub_we` and `lrf_we` are all low.
- R2: The first hub request of a burst is issued in the first cycle after command acceptance in which `slot_sel` equals the low `log2(NSLICE)` bits of the long address (byte address bits [4:2] when `NSLICE`=8). This wait is at most `NSLICE-1` cycles, and every request targets the slice offered in its cycle.
- R3: A length field of L moves exactly L+1 longs; L=0 moves one long.
- R4: After the first request, requests follow on every clock with no gap, and each request's long address is the previous one plus one.
- R5: With `start_dir`=0 (hub to local), `hub_we` is low, and the data returned on `hub_rdata` in the cycle after each request is written to the local index for that request.
- R6: With `start_dir`=1 (local to hub), `hub_we` is high on every request, and `hub_wdata` equals the register file entry at the current index, read through `lrf_raddr`/`lrf_rdata` in that same cycle.
- R7: Byte address bits [1:0] are ignored, and `hub_be` is 4'hF on every request.
- R8: The local index starts at `start_lrf_idx`, rises by one per long and wraps modulo the register file depth.
- R9: A burst passing the last populated long continues at long address zero.
- R10: A `start` pulse while `busy` is high is ignored: the running burst and all memory contents are as if it never came.
- R11: `busy` is high from the cycle after acceptance until `done`. `done` is high for exactly one cycle: the cycle after the last request for writes, and two cycles after it for reads, after the last local write. `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted only while idle |
| start_dir | input | 1 | 0 = hub to local, 1 = local to hub |
| start_hub_addr | input | HUB_AW+2 | Byte start address in the hub |
| start_lrf_idx | input | LRF_AW | First register file index |
| start_len_m1 | input | CNT_W | Number of longs minus one |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| slot_sel | input | log2(NSLICE) | Slice offered to this port in the current cycle |
| hub_req | output | 1 | Hub access this cycle |
| hub_we | output | 1 | Hub access is a write |
| hub_be | output | 4 | Byte enables |
| hub_addr | output | HUB_AW | Long address |
| hub_wdata | output | 32 | Hub write data |
| hub_rdata | input | 32 | Hub read data, one cycle after the request |
| lrf_we | output | 1 | Register file write enable |
| lrf_waddr | output | LRF_AW | Register file write index |
| lrf_wdata | output | 32 | Register file write data |
| lrf_raddr | output | LRF_AW | Register file read index |
| lrf_rdata | input | 32 | Register file read data, combinational |

## Verification
The hardest case to reach is a particular alignment wait. The wait depends on the phase of a free-running rotation at the moment the command is taken, which the ports cannot set directly. The bench runs its own slot counter and reads its phase in the first waiting cycle. It sweeps all eight start slices across many lengths and directions, so every wait from zero to seven occurs and each one is predicted arithmetically. A second hard case is a command that arrives in mid-burst. The bench raises a conflicting start during a long burst and then compares the whole hub and register file contents against its own model.

// File: rtl/hbe_pkg.sv
package hbe_pkg;

    localparam int unsigned HBE_LONG_W   = 32;
    localparam int unsigned HBE_BE_W     = 4;
    localparam int unsigned HBE_BYTE_OFS = 2;

    typedef logic [HBE_LONG_W-1:0] hbe_long_t;
    typedef logic [HBE_BE_W-1:0]   hbe_be_t;

    typedef enum logic [1:0] {
        HBE_IDLE  = 2'd0,
        HBE_WAIT  = 2'd1,
        HBE_XFER  = 2'd2,
        HBE_DRAIN = 2'd3
    } hbe_state_e;

    typedef enum logic {
        HBE_TO_LOCAL = 1'b0,
        HBE_TO_HUB   = 1'b1
    } hbe_dir_e;

    typedef struct packed {
        logic load;
        logic issue;
        logic finish;
    } hbe_ctl_t;

    function automatic hbe_be_t hbe_lanes(input logic active);
        return active ? {HBE_BE_W{1'b1}} : {HBE_BE_W{1'b0}};
    endfunction

endpackage

// File: rtl/hbe_align.sv
module hbe_align #(
    parameter int SLICE_W = 3,
    parameter int HUB_AW  = 17
) (
    input  logic [SLICE_W-1:0] slot_sel,
    input  logic [HUB_AW-1:0]  cur_addr,
    output logic               hit
);
    generate
        if (HUB_AW >= SLICE_W) begin : g_cmp
            assign hit = (cur_addr[SLICE_W-1:0] == slot_sel);
        end else begin : g_small
            assign hit = (SLICE_W'(cur_addr) == slot_sel);
        end
    endgenerate
endmodule

// File: rtl/hbe_counters.sv
module hbe_counters #(
    parameter int HUB_AW = 17,
    parameter int LRF_AW = 9,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [HUB_AW-1:0] ld_addr,
    input  logic [LRF_AW-1:0] ld_idx,
    input  logic [CNT_W-1:0]  ld_len,
    output logic [HUB_AW-1:0] cur_addr,
    output logic [LRF_AW-1:0] cur_idx,
    output logic              last
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_idx  <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            cur_idx  <= ld_idx;
            remain   <= ld_len;
        end else if (step) begin
            cur_addr <= cur_addr + HUB_AW'(1);
            cur_idx  <= cur_idx + LRF_AW'(1);
            remain   <= remain - CNT_W'(1);
        end
    end

    assign last = (remain == '0);
endmodule

// File: rtl/hbe_ctrl.sv
module hbe_ctrl
    import hbe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  hbe_dir_e start_dir,
    input  logic     hit,
    input  logic     last,
    output hbe_ctl_t ctl,
    output hbe_dir_e dir_q,
    output logic     busy,
    output logic     done
);
    hbe_state_e st, nxt;

    always_comb begin
        nxt        = st;
        ctl        = '0;
        unique case (st)
            HBE_IDLE: begin
                if (start) begin
                    nxt      = HBE_WAIT;
                    ctl.load = 1'b1;
                end
            end
            HBE_WAIT, HBE_XFER: begin
                if (st == HBE_XFER || hit) begin
                    ctl.issue = 1'b1;
                    if (!last) begin
                        nxt = HBE_XFER;
                    end else if (dir_q == HBE_TO_HUB) begin
                        nxt        = HBE_IDLE;
                        ctl.finish = 1'b1;
                    end else begin
                        nxt = HBE_DRAIN;
                    end
                end
            end
            HBE_DRAIN: begin
                nxt        = HBE_IDLE;
                ctl.finish = 1'b1;
            end
            default: nxt = HBE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= HBE_IDLE;
            done  <= 1'b0;
            dir_q <= HBE_TO_LOCAL;
        end else begin
            st   <= nxt;
            done <= ctl.finish;
            if (ctl.load) dir_q <= start_dir;
        end
    end

    assign busy = (st != HBE_IDLE);
endmodule

// File: rtl/hbe_rd_ret.sv
module hbe_rd_ret #(
    parameter int LRF_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LRF_AW-1:0] idx_in,
    output logic              we,
    output logic [LRF_AW-1:0] waddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we    <= 1'b0;
            waddr <= '0;
        end else begin
            we <= capture;
            if (capture) waddr <= idx_in;
        end
    end
endmodule

// File: rtl/hub_burst_engine.sv
module hub_burst_engine
    import hbe_pkg::*;
#(
    parameter int NSLICE = 8,
    parameter int HUB_AW = 17,
    parameter int LRF_AW = 9,
    parameter int CNT_W  = 9,
    localparam int SLICE_W = $clog2(NSLICE)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 start_dir,
    input  logic [HUB_AW+1:0]    start_hub_addr,
    input  logic [LRF_AW-1:0]    start_lrf_idx,
    input  logic [CNT_W-1:0]     start_len_m1,
    output logic                 busy,
    output logic                 done,
    input  logic [SLICE_W-1:0]   slot_sel,
    output logic                 hub_req,
    output logic                 hub_we,
    output logic [3:0]           hub_be,
    output logic [HUB_AW-1:0]    hub_addr,
    output logic [31:0]          hub_wdata,
    input  logic [31:0]          hub_rdata,
    output logic                 lrf_we,
    output logic [LRF_AW-1:0]    lrf_waddr,
    output logic [31:0]          lrf_wdata,
    output logic [LRF_AW-1:0]    lrf_raddr,
    input  logic [31:0]          lrf_rdata
);
    hbe_ctl_t          ctl;
    hbe_dir_e          dir_q;
    logic              hit;
    logic              last;
    logic [HUB_AW-1:0] cur_addr;
    logic [LRF_AW-1:0] cur_idx;
    logic              lane_bits_unused;

    assign lane_bits_unused = ^start_hub_addr[HBE_BYTE_OFS-1:0];

    hbe_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_dir (hbe_dir_e'(start_dir)),
        .hit       (hit),
        .last      (last),
        .ctl       (ctl),
        .dir_q     (dir_q),
        .busy      (busy),
        .done      (done)
    );

    hbe_align #(.SLICE_W(SLICE_W), .HUB_AW(HUB_AW)) u_align (
        .slot_sel (slot_sel),
        .cur_addr (cur_addr),
        .hit      (hit)
    );

    hbe_counters #(.HUB_AW(HUB_AW), .LRF_AW(LRF_AW), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .step     (ctl.issue),
        .ld_addr  (start_hub_addr[HUB_AW+1:HBE_BYTE_OFS]),
        .ld_idx   (start_lrf_idx),
        .ld_len   (start_len_m1),
        .cur_addr (cur_addr),
        .cur_idx  (cur_idx),
        .last     (last)
    );

    hbe_rd_ret #(.LRF_AW(LRF_AW)) u_ret (
        .clk     (clk),
        .rst     (rst),
        .capture (ctl.issue && dir_q == HBE_TO_LOCAL),
        .idx_in  (cur_idx),
        .we      (lrf_we),
        .waddr   (lrf_waddr)
    );

    assign hub_req   = ctl.issue;
    assign hub_we    = ctl.issue && (dir_q == HBE_TO_HUB);
    assign hub_be    = hbe_lanes(ctl.issue);
    assign hub_addr  = cur_addr;
    assign hub_wdata = hub_we ? lrf_rdata : '0;
    assign lrf_raddr = cur_idx;
    assign lrf_wdata = hub_rdata;
endmodule

// File: rtl/hbe_checker.sv
module hbe_checker #(
    parameter int SLICE_W = 3,
    parameter int HUB_AW  = 17
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic [SLICE_W-1:0] slot_sel,
    input logic               hub_req,
    input logic               hub_we,
    input logic [3:0]         hub_be,
    input logic [HUB_AW-1:0]  hub_addr,
    input logic               lrf_we
);
    assert_slot_match_R2: assert property (@(posedge clk) disable iff (rst)
        hub_req |-> (hub_addr[SLICE_W-1:0] == slot_sel));

    assert_stream_ascend_R4: assert property (@(posedge clk) disable iff (rst)
        (hub_req && $past(hub_req)) |-> (hub_addr == HUB_AW'($past(hub_addr) + 1'b1)));

    assert_local_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        lrf_we |-> $past(hub_req && !hub_we));

    assert_full_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        hub_req |-> (hub_be == 4'hF));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!hub_req && !hub_we));
endmodule

bind hub_burst_engine hbe_checker #(.SLICE_W(SLICE_W), .HUB_AW(HUB_AW)) u_hbe_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .slot_sel (slot_sel),
    .hub_req  (hub_req),
    .hub_we   (hub_we),
    .hub_be   (hub_be),
    .hub_addr (hub_addr),
    .lrf_we   (lrf_we)
);

// File: tb/sim_hub_burst_engine.sv
module sim_hub_burst_engine;
    localparam int NS  = 8;
    localparam int SW  = 3;
    localparam int HAW = 6;
    localparam int LAW = 4;
    localparam int CW  = 6;
    localparam int HN  = 1 << HAW;
    localparam int LN  = 1 << LAW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           start_dir = 1'b0;
    logic [HAW+1:0] start_hub_addr = '0;
    logic [LAW-1:0] start_lrf_idx = '0;
    logic [CW-1:0]  start_len_m1 = '0;
    logic           busy, done;
    logic [SW-1:0]  slot;
    logic           hub_req, hub_we;
    logic [3:0]     hub_be;
    logic [HAW-1:0] hub_addr;
    logic [31:0]    hub_wdata, hub_rdata;
    logic           lrf_we;
    logic [LAW-1:0] lrf_waddr, lrf_raddr;
    logic [31:0]    lrf_wdata, lrf_rdata;

    logic [31:0] mem [HN];
    logic [31:0] lrf [LN];
    logic [31:0] ref_mem [HN];
    logic [31:0] ref_lrf [LN];

    int checks = 0;
    int errors = 0;
    int slot_miss = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hub_burst_engine #(.NSLICE(NS), .HUB_AW(HAW), .LRF_AW(LAW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_dir(start_dir),
        .start_hub_addr(start_hub_addr), .start_lrf_idx(start_lrf_idx),
        .start_len_m1(start_len_m1), .busy(busy), .done(done), .slot_sel(slot),
        .hub_req(hub_req), .hub_we(hub_we), .hub_be(hub_be), .hub_addr(hub_addr),
        .hub_wdata(hub_wdata), .hub_rdata(hub_rdata), .lrf_we(lrf_we),
        .lrf_waddr(lrf_waddr), .lrf_wdata(lrf_wdata), .lrf_raddr(lrf_raddr),
        .lrf_rdata(lrf_rdata)
    );

    function automatic logic [31:0] mem_init(input int i);
        return 32'hC3A50000 ^ (i * 32'h00010203);
    endfunction
    function automatic logic [31:0] lrf_init(input int i);
        return 32'h5A000000 + (i * 32'h00110011);
    endfunction

    // rotating memory model with one-cycle read latency
    always @(posedge clk) begin
        if (rst) begin
            slot <= 3'd5;
            hub_rdata <= '0;
            for (int i = 0; i < HN; i++) mem[i] <= mem_init(i);
        end else begin
            slot <= slot + 3'd1;
            if (hub_req) begin
                if (hub_addr[SW-1:0] != slot) slot_miss <= slot_miss + 1;
                if (hub_we) mem[hub_addr] <= hub_wdata;
                else        hub_rdata <= mem[hub_addr];
            end
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LN; i++) lrf[i] <= lrf_init(i);
        end else if (lrf_we) begin
            lrf[lrf_waddr] <= lrf_wdata;
        end
    end
    assign lrf_rdata = lrf[lrf_raddr];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare_arrays(input string tag);
        int bad_m = 0;
        int bad_l = 0;
        for (int i = 0; i < HN; i++) if (mem[i] !== ref_mem[i]) bad_m++;
        for (int i = 0; i < LN; i++) if (lrf[i] !== ref_lrf[i]) bad_l++;
        check(bad_m == 0, {"R3/R6/R9 hub contents ", tag}, bad_m, 0);
        check(bad_l == 0, {"R5/R8 local contents ", tag}, bad_l, 0);
    endtask

    task automatic run_burst(input bit dir, input logic [HAW+1:0] baddr,
                             input logic [LAW-1:0] idx, input logic [CW-1:0] lm1,
                             input bit poke);
        int s0, wt, n, dn, k;
        bit ereq;
        logic [HAW-1:0] ea;
        logic [LAW-1:0] ei;
        @(negedge clk);
        start = 1'b1; start_dir = dir; start_hub_addr = baddr;
        start_lrf_idx = idx; start_len_m1 = lrf_idx_guard(lm1);
        @(negedge clk);
        start = 1'b0;
        s0 = int'(slot);
        wt = (int'(baddr[SW+1:2]) - s0 + NS) % NS;
        n  = int'(lm1) + 1;
        dn = wt + n + (dir ? 0 : 1);
        for (int t = 0; t <= dn; t++) begin
            ereq = (t >= wt) && (t < wt + n);
            check(hub_req == ereq, "R2/R4 request timing", hub_req, ereq);
            check(busy == (t < dn), "R11 busy", busy, (t < dn));
            check(done == (t == dn), "R11 done", done, (t == dn));
            if (ereq) begin
                k  = t - wt;
                ea = baddr[HAW+1:2] + HAW'(k);
                ei = idx + LAW'(k);
                check(hub_addr == ea, "R9 address", hub_addr, ea);
                check(hub_we == dir, "R5/R6 direction", hub_we, dir);
                check(hub_be == 4'hF, "R7 lanes", hub_be, 4'hF);
                if (dir) begin
                    check(hub_wdata == ref_lrf[ei], "R6 write data", hub_wdata, ref_lrf[ei]);
                    ref_mem[ea] = ref_lrf[ei];
                end else begin
                    ref_lrf[ei] = ref_mem[ea];
                end
            end
            if (poke && t == 1) begin
                start = 1'b1; start_dir = ~dir;
                start_hub_addr = baddr + 8'd20; start_lrf_idx = idx + 4'd3;
                start_len_m1 = 6'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(!busy && !done, "R11 idle after done", {busy, done}, 0);
        compare_arrays(poke ? "R10 after poke" : "after burst");
    endtask

    function automatic logic [CW-1:0] lrf_idx_guard(input logic [CW-1:0] v);
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < HN; i++) ref_mem[i] = mem_init(i);
        for (int i = 0; i < LN; i++) ref_lrf[i] = lrf_init(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !hub_req && !hub_we && !lrf_we, "R1 reset state",
              {busy, done, hub_req, hub_we, lrf_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !hub_req && !hub_we && !lrf_we, "R1 after reset",
              {busy, done, hub_req, hub_we, lrf_we}, 0);

        // sweep: direction x start slice x length, with low byte bits varied (R7)
        for (int d = 0; d < 2; d++) begin
            for (int a = 0; a < NS; a++) begin
                for (int l = 0; l < 5; l++) begin
                    logic [CW-1:0] lens [5] = '{6'd0, 6'd1, 6'd6, 6'd13, 6'd63};
                    logic [HAW+1:0] ba;
                    ba = {HAW'(a * 9 + l * 8), 2'(a + l)};
                    run_burst(d[0], ba, LAW'(a * 5 + l), lens[l], 1'b0);
                end
            end
        end
        // R3 single long, R9 hub wrap, R8 local wrap
        run_burst(1'b1, {6'd62, 2'b11}, 4'd14, 6'd9, 1'b0);
        run_burst(1'b0, {6'd60, 2'b01}, 4'd13, 6'd11, 1'b0);
        run_burst(1'b0, {6'd7, 2'b00}, 4'd15, 6'd0, 1'b0);
        // R10 start while busy
        run_burst(1'b1, {6'd33, 2'b10}, 4'd2, 6'd30, 1'b1);
        run_burst(1'b0, {6'd40, 2'b00}, 4'd9, 6'd30, 1'b1);

        check(slot_miss == 0, "R2 slice match", slot_miss, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule